// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Edge and Level Interrupts

This block is a general-purpose I/O controller for up to 32 pins. Software reaches it through a simple 32-bit register port that carries a word index. Each register is 32 bits wide, and bit n always belongs to pin n. For each pin the controller holds an input gate, an output-enable bit, an output value and an output inversion bit. The pad-side output is the output value XORed with the inversion bit. Pad inputs pass through a two-flop synchronizer. The synchronized level, masked by the input gate, can be read back.

Every synchronized input feeds four interrupt sources: rising edge, falling edge, high level and low level. Each source has its own enable register and its own sticky pending register, and software clears a pending bit by writing 1 to it. Each pin drives a dedicated interrupt line. That line is active while any of its four sources has a pending bit that is also enabled. An interrupt controller outside this block collects the lines. The bus bridge and pin multiplexing also sit outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `pad_oe`, `pad_out` and `pin_irq` are all zero.
- R2: The word indices are: input level 0x00, input gate 0x01, output enable 0x02, output value 0x03, rise enable 0x06, rise pending 0x07, fall enable 0x08, fall pending 0x09, high enable 0x0A, high pending 0x0B, low enable 0x0C, low pending 0x0D, output inversion 0x10. A read of an enable, output or inversion register returns the last value written to it.
- R3: `pad_oe` equals the output-enable register, and `pad_out` equals the output value XOR the inversion register.
- R4: A read of the input level register returns the synchronized pad level ANDed with the input gate. A pad change made before clock edge k is visible to reads accepted at edge k+2 or later.
- R5: A rise pending bit sets when the synchronized level of its pin goes from 0 to 1. This happens whether or not the bit's enable is set.
- R6: A fall pending bit sets when the synchronized level of its pin goes from 1 to 0. This happens whether or not the bit's enable is set.
- R7: A high pending bit sets while the synchronized level is 1, and a low pending bit sets while it is 0; low pending therefore sets soon after reset on a pin held low. If the level still persists after a clear, the bit sets again on the following cycle.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. In the cycle of the clear, the clear takes priority over a new set. Otherwise a pending bit holds its value.
- R9: After a clear, an edge pending bit stays clear until a new edge of its kind occurs.
- R10: `pin_irq[n]` is 1 exactly when at least one source has both its pending bit n and its enable bit n set.
- R11: Writes to the input level register and to unmapped indices change nothing, and reads of unmapped indices return zero.
- R12: A read request accepted at a clock edge raises `rd_valid` for the next cycle, with `rd_data` holding the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 6 | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pin_irq | output | NPINS | Per-pin interrupt lines |

## Verification
The pads are first driven with one bit pattern and then changed to a second pattern. As a result, the same word contains pins that rise, pins that fall, pins that hold high and pins that hold low. This shows whether each pending register responds only to its own condition. All pending registers are cleared while the pad levels are held, which separates level sources (they set again) from edge sources (they stay clear). Clears are tried with zero and with single bits, and enables are switched one source at a time. This shows that each interrupt line follows only its own enabled sources.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned WORD_W = 6;
  localparam int unsigned N_SRC  = 4;

  // source order inside the controller: rise, fall, high, low
  localparam int unsigned SRC_RISE = 0;
  localparam int unsigned SRC_FALL = 1;
  localparam int unsigned SRC_HIGH = 2;
  localparam int unsigned SRC_LOW  = 3;

  localparam logic [WORD_W-1:0] W_PIN_LVL = 6'h00;
  localparam logic [WORD_W-1:0] W_IN_GATE = 6'h01;
  localparam logic [WORD_W-1:0] W_OUT_EN  = 6'h02;
  localparam logic [WORD_W-1:0] W_OUT_VAL = 6'h03;
  localparam logic [WORD_W-1:0] W_SRC_EN0 = 6'h06; // enable of source s at +2*s, pending at +2*s+1
  localparam logic [WORD_W-1:0] W_INVERT  = 6'h10;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  always_comb begin
    lvl_o  = lvl_q;
    rise_o = lvl_q & ~prev_q;
    fall_o = ~lvl_q & prev_q;
  end

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
  // R6
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] pend_q, pend_d;

  always_comb pend_d = (pend_q | set_i) & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_o & $past(clr_i)) == '0));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o != '0) |=> (((($past(pend_o) & ~$past(clr_i))) & ~pend_o) == '0));
  // R5
  set_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> (((($past(set_i) & ~$past(clr_i))) & ~pend_o) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_word,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pin_irq
);
  logic [NPINS-1:0] wdat;
  logic             wr_go, rd_go;

  logic [NPINS-1:0] gate_q, oen_q, oval_q, inv_q;
  logic [NPINS-1:0] gate_d, oen_d, oval_d, inv_d;
  logic [NPINS-1:0] src_en_q [N_SRC];
  logic [NPINS-1:0] src_pd   [N_SRC];
  logic [NPINS-1:0] src_set  [N_SRC];
  logic [NPINS-1:0] src_clr  [N_SRC];

  logic [NPINS-1:0] lvl, rise, fall;
  logic             mapped;
  logic [31:0]      rd_d;
  logic             rdv_d;

  assign wdat  = req_wdata[NPINS-1:0];
  assign wr_go = req_valid & req_write;
  assign rd_go = req_valid & ~req_write;

  gpio_pin_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_in),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    src_set[SRC_RISE] = rise;
    src_set[SRC_FALL] = fall;
    src_set[SRC_HIGH] = lvl;
    src_set[SRC_LOW]  = ~lvl;
  end

  // plain control registers
  always_comb begin
    gate_d = gate_q;
    oen_d  = oen_q;
    oval_d = oval_q;
    inv_d  = inv_q;
    if (wr_go) begin
      case (req_word)
        W_IN_GATE: gate_d = wdat;
        W_OUT_EN:  oen_d  = wdat;
        W_OUT_VAL: oval_d = wdat;
        W_INVERT:  inv_d  = wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      oen_q  <= '0;
      oval_q <= '0;
      inv_q  <= '0;
    end else begin
      gate_q <= gate_d;
      oen_q  <= oen_d;
      oval_q <= oval_d;
      inv_q  <= inv_d;
    end
  end

  // per-source enable and pending banks
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam logic [WORD_W-1:0] EN_W = W_SRC_EN0 + WORD_W'(2 * s);
    localparam logic [WORD_W-1:0] PD_W = EN_W + WORD_W'(1);
    logic             en_hit;
    logic [NPINS-1:0] en_d;

    assign en_hit     = wr_go && (req_word == EN_W);
    assign src_clr[s] = (wr_go && (req_word == PD_W)) ? wdat : '0;

    always_comb en_d = en_hit ? wdat : src_en_q[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_en_q[s] <= '0;
      else        src_en_q[s] <= en_d;
    end

    gpio_pend_bank #(.NPINS(NPINS)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .set_i(src_set[s]), .clr_i(src_clr[s]), .pend_o(src_pd[s])
    );
  end

  // interrupt lines
  always_comb begin
    pin_irq = '0;
    for (int s = 0; s < N_SRC; s++) pin_irq = pin_irq | (src_pd[s] & src_en_q[s]);
  end

  assign pad_oe  = oen_q;
  assign pad_out = oval_q ^ inv_q;

  // read path
  always_comb begin
    rd_d   = '0;
    mapped = 1'b1;
    case (req_word)
      W_PIN_LVL:      rd_d = 32'(lvl & gate_q);
      W_IN_GATE:      rd_d = 32'(gate_q);
      W_OUT_EN:       rd_d = 32'(oen_q);
      W_OUT_VAL:      rd_d = 32'(oval_q);
      W_INVERT:       rd_d = 32'(inv_q);
      W_SRC_EN0:      rd_d = 32'(src_en_q[SRC_RISE]);
      W_SRC_EN0 + 1:  rd_d = 32'(src_pd[SRC_RISE]);
      W_SRC_EN0 + 2:  rd_d = 32'(src_en_q[SRC_FALL]);
      W_SRC_EN0 + 3:  rd_d = 32'(src_pd[SRC_FALL]);
      W_SRC_EN0 + 4:  rd_d = 32'(src_en_q[SRC_HIGH]);
      W_SRC_EN0 + 5:  rd_d = 32'(src_pd[SRC_HIGH]);
      W_SRC_EN0 + 6:  rd_d = 32'(src_en_q[SRC_LOW]);
      W_SRC_EN0 + 7:  rd_d = 32'(src_pd[SRC_LOW]);
      default:        mapped = 1'b0;
    endcase
    rdv_d = rd_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rdv_d;
      if (rd_go) rd_data <= rd_d;
    end
  end

  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !mapped) |=> (rd_data == '0));
  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_word == W_OUT_EN) |=> (pad_oe == $past(wdat)));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq != '0) |-> ((src_en_q[SRC_RISE] | src_en_q[SRC_FALL] |
                          src_en_q[SRC_HIGH] | src_en_q[SRC_LOW]) != '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [5:0] req_word;
  logic [31:0] req_wdata;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pin_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_irq(pin_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] w, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [5:0] w, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 actual=unexpected rd_valid expected=no response");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_word = '0; req_wdata = '0; pad_in = '0;
    idle(3);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pin_irq", pin_irq, 32'h0);
    rst_n = 1'b1;
    idle(2);
    rd(6'h01, 32'h0, "R1 gate");
    rd(6'h02, 32'h0, "R1 oe");
    rd(6'h06, 32'h0, "R1 rise_en");
    chk("R1 pin_irq after", pin_irq, 32'h0);

    // R2 R3
    wr(6'h02, 32'hA5A5_0F0F);
    wr(6'h03, 32'h1234_5678);
    wr(6'h10, 32'hFFFF_0000);
    rd(6'h02, 32'hA5A5_0F0F, "R2 oe readback");
    rd(6'h03, 32'h1234_5678, "R2 oval readback");
    rd(6'h10, 32'hFFFF_0000, "R2 inv readback");
    chk("R3 pad_oe", pad_oe, 32'hA5A5_0F0F);
    chk("R3 pad_out", pad_out, 32'h1234_5678 ^ 32'hFFFF_0000);

    // R4 R11
    wr(6'h01, 32'h0000_00FF);
    pad_in = 32'h0000_0F0F;
    idle(4);
    rd(6'h00, 32'h0000_000F, "R4 gated level");
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0000_000F, "R11 level write ignored");
    rd(6'h01, 32'h0000_00FF, "R11 gate untouched");
    wr(6'h11, 32'hDEAD_BEEF);
    rd(6'h11, 32'h0, "R11 unmapped read");
    rd(6'h3F, 32'h0, "R11 unmapped high read");

    // clear every pending bank while pads hold 0x0F0F
    wr(6'h07, 32'hFFFF_FFFF);
    wr(6'h09, 32'hFFFF_FFFF);
    wr(6'h0B, 32'hFFFF_FFFF);
    wr(6'h0D, 32'hFFFF_FFFF);
    idle(2);
    rd(6'h07, 32'h0, "R9 rise stays clear");
    rd(6'h09, 32'h0, "R9 fall stays clear");
    rd(6'h0B, 32'h0000_0F0F, "R7 high re-sets");
    rd(6'h0D, 32'hFFFF_F0F0, "R7 low re-sets");

    // new pattern: bits 4-7 rise, bits 8-11 fall
    pad_in = 32'h0000_00FF;
    idle(5);
    rd(6'h07, 32'h0000_00F0, "R5 rise pending");
    rd(6'h09, 32'h0000_0F00, "R6 fall pending");
    rd(6'h0B, 32'h0000_0FFF, "R7 high sticky");
    rd(6'h0D, 32'hFFFF_FFF0, "R7 low sticky");

    // R8
    wr(6'h07, 32'h0);
    rd(6'h07, 32'h0000_00F0, "R8 zero write keeps");
    wr(6'h07, 32'h0000_0010);
    rd(6'h07, 32'h0000_00E0, "R8 single clear");
    wr(6'h0B, 32'hFFFF_FFFF);
    idle(2);
    rd(6'h0B, 32'h0000_00FF, "R7 high after clear");

    // R10
    wr(6'h06, 32'h0000_0020);
    chk("R10 rise enabled", pin_irq, 32'h0000_0020);
    rd(6'h06, 32'h0000_0020, "R2 rise_en readback");
    wr(6'h0A, 32'h0000_0001);
    chk("R10 high added", pin_irq, 32'h0000_0021);
    wr(6'h07, 32'h0000_0020);
    chk("R10 rise cleared", pin_irq, 32'h0000_0001);
    wr(6'h0A, 32'h0);
    wr(6'h0C, 32'h0000_0100);
    chk("R10 low only", pin_irq, 32'h0000_0100);

    idle(3);
    chk("R12 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule